// File: doc/BRIEF.md
# Masked Interrupt Combiner

This block gathers up to 32 interrupt request lines into one interrupt output for a bus master. Each line passes through its own detector, chosen at build time from four trigger modes: high level, low level, rising edge or falling edge. A detected event latches a pending bit, but only when that line is currently enabled. The single output is a registered OR of every pending bit whose enable is also set.

Software uses four register views. Each view is a data word with a one-cycle write strobe, or a plain read word. One word sets enable bits and another clears them, so no single write can overwrite the whole enable set. The enable state can be read back as a mask word. The status word shows the pending bits, and writing ones to it acknowledges them. Address decoding and the bus protocol sit outside the block. It only takes strobes and data words and drives the read views.

The asynchronous reset input is released through a two-stage synchronizer inside the block. The first strobe is therefore taken on the third rising clock edge after the reset input goes high.

Top module: `intc_core`

## Requirements
- R1: After reset, the mask word, the status word and the interrupt output are all 0.
- R2: A cycle with the enable-set strobe high sets the mask bit at every position where the set word holds 1. All other mask bits keep their values.
- R3: A cycle with the enable-clear strobe high clears the mask bit at every position where the clear word holds 1. All other mask bits keep their values.
- R4: If the set and clear strobes target the same mask bit in the same cycle, that bit ends cleared. Bits named only by the set word are still set.
- R5: A line whose mask bit is 0 never sets its status bit, and the interrupt output stays 0.
- R6: A line with trigger code 0 (high level) sets its status bit after every clock edge at which the line is 1 and enabled.
- R7: A line with trigger code 1 (low level) sets its status bit when the line is 0. Holding the line at 1 causes no pending bit.
- R8: A line with trigger code 2 (rising edge) sets its status bit once per 0-to-1 transition. Holding the line at 1 after an acknowledge does not set the bit again.
- R9: A line with trigger code 3 (falling edge) sets its status bit once per 1-to-0 transition. Holding the line at 1 or at 0 raises nothing new.
- R10: A cycle with the acknowledge strobe high clears every status bit where the acknowledge word holds 1. Bits where it holds 0 are unchanged.
- R11: When a detected event and an acknowledge hit the same status bit in the same cycle, the bit stays set.
- R12: The interrupt output is 1 exactly one cycle after some status bit and its mask bit are both 1. A pending bit whose mask bit was cleared does not drive the output.
- R13: Trigger codes are set in a parameter vector with 2 bits per line, line i at bits 2i+1:2i. Positions that are not given default to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | NUM_LINES | Interrupt request lines, synchronous to clk |
| en_set_data_i | input | NUM_LINES | Enable-set word (ones set mask bits) |
| en_set_stb_i | input | 1 | One-cycle strobe for the enable-set word |
| en_clr_data_i | input | NUM_LINES | Enable-clear word (ones clear mask bits) |
| en_clr_stb_i | input | 1 | One-cycle strobe for the enable-clear word |
| ack_data_i | input | NUM_LINES | Acknowledge word (ones clear status bits) |
| ack_stb_i | input | 1 | One-cycle strobe for the acknowledge word |
| mask_o | output | NUM_LINES | Read view of the enable mask |
| status_o | output | NUM_LINES | Read view of the pending bits |
| irq_o | output | 1 | Combined, registered interrupt output |

## Verification
The bench gives four lines four different trigger codes. Each is driven with a held level, a one-cycle pulse, and a hold after acknowledge. This separates level detection from edge detection and shows that polarity is applied per line. The enable tests use overlapping and disjoint set and clear words, and this exposes a mask that loses untouched bits or resolves a conflict the wrong way. Acknowledges are issued with a zero word, while the line is idle, and while the line still asserts. This separates write-one-to-clear behaviour from event priority. Clearing an enable while a bit is pending shows that the output is gated by the mask and not by the status alone.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned MAX_LINES = 32;
  localparam int unsigned MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    TRIG_LVL_HI  = 2'd0,
    TRIG_LVL_LO  = 2'd1,
    TRIG_RISE    = 2'd2,
    TRIG_FALL    = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/intc_detect.sv
module intc_detect
  import intc_pkg::*;
#(
  parameter logic [MODE_W-1:0] MODE = 2'd0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic event_o
);
  localparam trig_mode_e TMODE = trig_mode_e'(MODE);
  // Inactive level is 1 for low-level and falling modes.
  localparam logic IDLE_LVL = MODE[0];

  logic hist_q;
  logic hist_d;

  always_comb begin
    hist_d = line_i;
    unique case (TMODE)
      TRIG_LVL_HI: event_o = line_i;
      TRIG_LVL_LO: event_o = ~line_i;
      TRIG_RISE:   event_o = line_i & ~hist_q;
      TRIG_FALL:   event_o = ~line_i & hist_q;
      default:     event_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= IDLE_LVL;
    else        hist_q <= hist_d;
  end

  generate
    if (MODE[1]) begin : g_edge_chk
      // R8 / R9: an edge detector cannot fire on two consecutive cycles
      a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |=> !event_o)
        else $error("edge detector fired twice in a row");
    end
  endgenerate
endmodule

// File: rtl/intc_mask.sv
module intc_mask #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] set_data_i,
  input  logic                 set_stb_i,
  input  logic [NUM_LINES-1:0] clr_data_i,
  input  logic                 clr_stb_i,
  output logic [NUM_LINES-1:0] mask_o
);
  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] mask_d;
  logic                 mask_en;
  logic [NUM_LINES-1:0] set_bits;
  logic [NUM_LINES-1:0] clr_bits;

  always_comb begin
    set_bits = set_stb_i ? set_data_i : '0;
    clr_bits = clr_stb_i ? clr_data_i : '0;
    mask_en  = set_stb_i | clr_stb_i;
    // clear is applied last so it wins over a same-cycle set
    mask_d   = (mask_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb_i && !clr_stb_i) |=> ((mask_q & $past(set_data_i)) == $past(set_data_i)))
    else $error("enable-set bit not applied");

  a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb_i |=> ((mask_q & $past(clr_data_i)) == '0))
    else $error("enable-clear bit not applied");

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb_i && !clr_stb_i) |=> $stable(mask_q))
    else $error("mask changed without a strobe");
endmodule

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] event_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] ack_data_i,
  input  logic                 ack_stb_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] pend_d;
  logic [NUM_LINES-1:0] hit;
  logic [NUM_LINES-1:0] ack_bits;
  logic                 pend_en;
  logic                 irq_q;
  logic                 irq_d;

  always_comb begin
    hit      = event_i & mask_i;
    ack_bits = ack_stb_i ? ack_data_i : '0;
    pend_en  = ack_stb_i | (|hit);
    // new events are merged after the acknowledge so they win
    pend_d   = (pend_q & ~ack_bits) | hit;
    irq_d    = |(pend_q & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  a_r5_no_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(mask_i)) == '0))
    else $error("pending bit set on a disabled line");

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb_i |=> ((pend_q & $past(ack_data_i) & ~$past(event_i & mask_i)) == '0))
    else $error("acknowledged bit still pending");

  a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(event_i & mask_i)) == $past(event_i & mask_i)))
    else $error("enabled event lost");
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter logic [MAX_LINES*MODE_W-1:0] LINE_MODES = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic [NUM_LINES-1:0] en_set_data_i,
  input  logic                 en_set_stb_i,
  input  logic [NUM_LINES-1:0] en_clr_data_i,
  input  logic                 en_clr_stb_i,
  input  logic [NUM_LINES-1:0] ack_data_i,
  input  logic                 ack_stb_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] status_o,
  output logic                 irq_o
);
  localparam int unsigned SYNC_STAGES = 2;

  initial begin
    if (NUM_LINES < 1 || NUM_LINES > MAX_LINES)
      $error("NUM_LINES out of range");
  end

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  logic [NUM_LINES-1:0] events;
  logic [NUM_LINES-1:0] mask;

  generate
    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
      intc_detect #(
        .MODE (LINE_MODES[gi*MODE_W +: MODE_W])
      ) u_det (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .line_i  (irq_lines_i[gi]),
        .event_o (events[gi])
      );
    end
  endgenerate

  intc_mask #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .set_data_i (en_set_data_i),
    .set_stb_i  (en_set_stb_i),
    .clr_data_i (en_clr_data_i),
    .clr_stb_i  (en_clr_stb_i),
    .mask_o     (mask)
  );

  intc_pend #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .event_i    (events),
    .mask_i     (mask),
    .ack_data_i (ack_data_i),
    .ack_stb_i  (ack_stb_i),
    .pend_o     (status_o),
    .irq_o      (irq_o)
  );

  assign mask_o = mask;

  a_r12_out_follows: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (irq_o == $past(|(status_o & mask_o))))
    else $error("combined output does not follow status and mask");

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (mask_o == '0 && status_o == '0 && !irq_o))
    else $error("state not cleared in reset");
endmodule

// File: tb/sim_intc_core.sv
module sim_intc_core;
  localparam int CLK_P = 10;
  localparam int N = 8;
  // line0 high level, line1 low level, line2 rising, line3 falling, rest code 0 (R13)
  localparam logic [63:0] MODES = 64'h0000_0000_0000_00E4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] lines = '0;
  logic [N-1:0] set_d = '0, clr_d = '0, ack_d = '0;
  logic set_s = 1'b0, clr_s = 1'b0, ack_s = 1'b0;
  logic [N-1:0] mask, status;
  logic irq;
  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  intc_core #(.NUM_LINES(N), .LINE_MODES(MODES)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
    .en_set_data_i(set_d), .en_set_stb_i(set_s),
    .en_clr_data_i(clr_d), .en_clr_stb_i(clr_s),
    .ack_data_i(ack_d), .ack_stb_i(ack_s),
    .mask_o(mask), .status_o(status), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // drive at a falling edge, release at the next; state visible there
  task automatic wr_set(input logic [N-1:0] d);
    set_d = d; set_s = 1'b1; step(); set_s = 1'b0; set_d = '0;
  endtask
  task automatic wr_clr(input logic [N-1:0] d);
    clr_d = d; clr_s = 1'b1; step(); clr_s = 1'b0; clr_d = '0;
  endtask
  task automatic wr_ack(input logic [N-1:0] d);
    ack_d = d; ack_s = 1'b1; step(); ack_s = 1'b0; ack_d = '0;
  endtask

  task automatic t_reset();
    chk("R1 mask", 32'(mask), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_mask();
    wr_set(8'h0F); chk("R2 set", 32'(mask), 32'h0F);
    wr_set(8'h30); chk("R2 others kept", 32'(mask), 32'h3F);
    wr_clr(8'h05); chk("R3 clear", 32'(mask), 32'h3A);
    set_d = 8'hC0; set_s = 1'b1; clr_d = 8'h40; clr_s = 1'b1; step();
    set_s = 1'b0; clr_s = 1'b0;
    chk("R4 clear wins", 32'(mask), 32'hBA);
    wr_clr(8'hFF); chk("R3 all", 32'(mask), 0);
  endtask

  task automatic t_gate();
    lines[0] = 1'b1; step(); step();
    chk("R5 status", 32'(status), 0);
    chk("R5 irq", 32'(irq), 0);
    lines[0] = 1'b0; step();
  endtask

  task automatic t_level_hi();
    wr_set(8'h01);
    lines[0] = 1'b1; step();
    chk("R6 pending", 32'(status), 32'h01);
    lines[0] = 1'b0; step();
    chk("R12 irq one cycle later", 32'(irq), 1);
    wr_ack(8'h00); chk("R10 zero word", 32'(status), 32'h01);
    wr_ack(8'h01); chk("R10 ack", 32'(status), 0);
    step(); chk("R12 irq low", 32'(irq), 0);
    lines[0] = 1'b1; step();
    wr_ack(8'h01); chk("R11 event wins", 32'(status), 32'h01);
    lines[0] = 1'b0; wr_ack(8'h01);
    chk("R6 cleared when idle", 32'(status), 0);
    lines[0] = 1'b1; step();
    wr_clr(8'h01); lines[0] = 1'b0;
    chk("R12 status kept", 32'(status), 32'h01);
    step(); chk("R12 masked pending no irq", 32'(irq), 0);
    wr_ack(8'h01);
  endtask

  task automatic t_level_lo();
    wr_set(8'h02); step();
    chk("R7 idle high", 32'(status), 0);
    lines[1] = 1'b0; step(); lines[1] = 1'b1;
    chk("R7 low pending", 32'(status), 32'h02);
    wr_ack(8'h02); chk("R7 ack", 32'(status), 0);
    wr_clr(8'h02);
  endtask

  task automatic t_rise();
    wr_set(8'h04);
    lines[2] = 1'b1; step();
    chk("R8 edge", 32'(status), 32'h04);
    wr_ack(8'h04); chk("R8 held no repeat", 32'(status), 0);
    step(); chk("R8 still none", 32'(status), 0);
    lines[2] = 1'b0; step(); lines[2] = 1'b1; step();
    chk("R8 second edge", 32'(status), 32'h04);
    lines[2] = 1'b0; wr_ack(8'h04); wr_clr(8'h04);
  endtask

  task automatic t_fall();
    wr_set(8'h08); step();
    chk("R9 held high", 32'(status), 0);
    lines[3] = 1'b0; step();
    chk("R9 edge", 32'(status), 32'h08);
    wr_ack(8'h08); step();
    chk("R9 held low", 32'(status), 0);
    lines[3] = 1'b1; step();
    chk("R9 rise ignored", 32'(status), 0);
    wr_clr(8'h08);
  endtask

  task automatic t_default_mode();
    wr_set(8'h80);
    lines[7] = 1'b1; step(); lines[7] = 1'b0;
    chk("R13 default code 0", 32'(status), 32'h80);
    wr_ack(8'h80); wr_clr(8'h80);
  endtask

  initial begin
    lines = 8'b0000_1010;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    t_reset();
    t_mask();
    t_gate();
    t_level_hi();
    t_level_lo();
    t_rise();
    t_fall();
    t_default_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule